// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is the output cell that sits between the OR array of a programmable sum-of-products device and one pin. It takes a small group of sum terms and combines them. It can invert the combined value, and it holds the result in one storage bit. That bit acts as a D, T, JK or SR flip-flop, depending on static configuration bits.

Two independent selectors decide what leaves the cell. One chooses between the stored bit and the combinational value for the pin. The other makes the same choice for the line that feeds back into the AND array. The feedback line keeps working when the pin driver is off, so the cell can be used as buried logic. A global asynchronous reset and a global asynchronous preset act on the stored bit, and reset wins when both are high. The pin enable is forced off while reset is high.

Top module: `omc_cell`

## Requirements
- R1: With cfg_mode=2'b00 (D), each rising clk edge loads the state with the OR of all sum terms XOR cfg_pol.
- R2: With cfg_mode=2'b01 (T), a rising edge inverts the state when (OR of all terms) XOR cfg_pol is 1. Otherwise the state holds.
- R3: With cfg_mode=2'b10 (JK), J is terms[0]|terms[1] and K is terms[2]|terms[3]. The edge action is: J=0,K=0 hold; J=1,K=0 set; J=0,K=1 clear; J=1,K=1 invert.
- R4: With cfg_mode=2'b11 (SR), S is terms[0]|terms[1] and R is terms[2]|terms[3]. S alone sets the state, R alone clears it, and neither or both leave it unchanged.
- R5: rst_gl high clears the state at once, without waiting for a clock edge, and it overrides pre_gl.
- R6: pre_gl high with rst_gl low sets the state at once, without waiting for a clock edge.
- R7: pin_out carries the state when cfg_pin_reg=1. When cfg_pin_reg=0 it carries (OR of all terms) XOR cfg_pol combinationally.
- R8: fb_out follows the same choice under its own bit, cfg_fb_reg, independently of cfg_pin_reg. It stays valid whatever the values of oe and pin_oe.
- R9: pin_oe equals oe while rst_gl is low and is 0 while rst_gl is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_gl | input | 1 | Asynchronous global reset, active high, clears the state |
| pre_gl | input | 1 | Asynchronous global preset, active high, sets the state |
| terms | input | NUM_TERMS | Sum terms from the OR array |
| cfg_mode | input | 2 | Storage behaviour: 00 D, 01 T, 10 JK, 11 SR |
| cfg_pol | input | 1 | Inverts the combined sum |
| cfg_pin_reg | input | 1 | 1: pin shows the state, 0: pin shows the combinational value |
| cfg_fb_reg | input | 1 | 1: feedback shows the state, 0: feedback shows the combinational value |
| oe | input | 1 | Pin output enable request |
| pin_out | output | 1 | Data toward the pin driver |
| pin_oe | output | 1 | Enable toward the pin driver |
| fb_out | output | 1 | Feedback into the AND array |

## Verification
The bench aims at the four JK and SR input pairs. A design that decoded S and R together as set or clear would corrupt the hold case, and one that swapped the term halves would set the bit where it should clear it. It holds reset and preset high together to catch the wrong priority. It also makes both changes between clock edges, so that a synchronous implementation would show a stale value. It sets the pin and feedback selectors to opposite values, with the pin disabled, to expose a shared selector or a feedback line gated by the enable. It also inverts the polarity in T mode, where a missing inversion turns hold into toggle.

// File: rtl/omc_pkg.sv
package omc_pkg;
    typedef enum logic [1:0] {
        MODE_D  = 2'b00,
        MODE_T  = 2'b01,
        MODE_JK = 2'b10,
        MODE_SR = 2'b11
    } ff_mode_e;

    typedef struct packed {
        logic state;
    } cell_regs_t;
endpackage

// File: rtl/omc_term_combine.sv
module omc_term_combine #(
    parameter int NUM_TERMS = 4
) (
    input  logic [NUM_TERMS-1:0] terms,
    input  logic                 pol,
    output logic                 sum_pol,
    output logic                 pair_lo,
    output logic                 pair_hi
);
    localparam int HALF = NUM_TERMS / 2;

    always_comb begin
        sum_pol = (|terms) ^ pol;
        pair_lo = |terms[HALF-1:0];
        pair_hi = |terms[NUM_TERMS-1:HALF];
    end
endmodule

// File: rtl/omc_next_state.sv
module omc_next_state
    import omc_pkg::*;
(
    input  ff_mode_e mode,
    input  logic     cur,
    input  logic     sum_pol,
    input  logic     pair_lo,
    input  logic     pair_hi,
    output logic     nxt
);
    always_comb begin
        nxt = cur;
        unique case (mode)
            MODE_D:  nxt = sum_pol;
            MODE_T:  nxt = cur ^ sum_pol;
            MODE_JK: nxt = (pair_lo & ~cur) | (~pair_hi & cur);
            MODE_SR: begin
                if (pair_lo && !pair_hi)      nxt = 1'b1;
                else if (pair_hi && !pair_lo) nxt = 1'b0;
                else                          nxt = cur;
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/omc_out_mux.sv
module omc_out_mux (
    input  logic sel_reg,
    input  logic reg_val,
    input  logic comb_val,
    output logic out
);
    always_comb out = sel_reg ? reg_val : comb_val;
endmodule

// File: rtl/omc_cell.sv
module omc_cell
    import omc_pkg::*;
#(
    parameter int NUM_TERMS = 4
) (
    input  logic                 clk,
    input  logic                 rst_gl,
    input  logic                 pre_gl,
    input  logic [NUM_TERMS-1:0] terms,
    input  logic [1:0]           cfg_mode,
    input  logic                 cfg_pol,
    input  logic                 cfg_pin_reg,
    input  logic                 cfg_fb_reg,
    input  logic                 oe,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 fb_out
);
    cell_regs_t regs_d, regs_q;
    ff_mode_e   mode;
    logic       sum_pol, pair_lo, pair_hi, nxt_state;

    assign mode = ff_mode_e'(cfg_mode);

    omc_term_combine #(.NUM_TERMS(NUM_TERMS)) u_comb (
        .terms   (terms),
        .pol     (cfg_pol),
        .sum_pol (sum_pol),
        .pair_lo (pair_lo),
        .pair_hi (pair_hi)
    );

    omc_next_state u_next (
        .mode    (mode),
        .cur     (regs_q.state),
        .sum_pol (sum_pol),
        .pair_lo (pair_lo),
        .pair_hi (pair_hi),
        .nxt     (nxt_state)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = nxt_state;
    end

    always_ff @(posedge clk or posedge rst_gl or posedge pre_gl) begin
        if (rst_gl)      regs_q       <= '0;
        else if (pre_gl) regs_q.state <= 1'b1;
        else             regs_q       <= regs_d;
    end

    omc_out_mux u_pin_mux (
        .sel_reg  (cfg_pin_reg),
        .reg_val  (regs_q.state),
        .comb_val (sum_pol),
        .out      (pin_out)
    );

    omc_out_mux u_fb_mux (
        .sel_reg  (cfg_fb_reg),
        .reg_val  (regs_q.state),
        .comb_val (sum_pol),
        .out      (fb_out)
    );

    assign pin_oe = oe & ~rst_gl;

    // R5: state reads zero whenever reset is high
    always @(negedge clk) begin
        if (rst_gl === 1'b1)
            a_r5_reset_clears: assert (regs_q.state == 1'b0);
    end

    // R9: pin never enabled during reset
    always @(negedge clk) begin
        if (rst_gl === 1'b1)
            a_r9_oe_released: assert (pin_oe == 1'b0);
    end

    // R1: D mode loads the polarised sum
    a_r1_d_load: assert property (@(posedge clk) disable iff (rst_gl || pre_gl)
        (mode == MODE_D) |=> (regs_q.state == $past(sum_pol)));

    // R2: T mode toggles on an active input
    a_r2_t_toggle: assert property (@(posedge clk) disable iff (rst_gl || pre_gl)
        (mode == MODE_T && sum_pol) |=> (regs_q.state != $past(regs_q.state)));

    // R3: JK with both inputs low holds
    a_r3_jk_hold: assert property (@(posedge clk) disable iff (rst_gl || pre_gl)
        (mode == MODE_JK && !pair_lo && !pair_hi) |=> $stable(regs_q.state));

    // R4: SR with both inputs high holds
    a_r4_sr_both_hold: assert property (@(posedge clk) disable iff (rst_gl || pre_gl)
        (mode == MODE_SR && pair_lo && pair_hi) |=> $stable(regs_q.state));
endmodule

// File: tb/test_omc_cell.sv
module test_omc_cell;
    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst_gl = 1'b1;
    logic          pre_gl = 1'b0;
    logic [NT-1:0] terms = '0;
    logic [1:0]    cfg_mode = 2'b00;
    logic          cfg_pol = 1'b0;
    logic          cfg_pin_reg = 1'b1;
    logic          cfg_fb_reg = 1'b1;
    logic          oe = 1'b0;
    logic          pin_out, pin_oe, fb_out;

    int total = 0;
    int bad = 0;
    bit drv_done = 1'b0;
    logic model_q = 1'b0;

    typedef struct {
        string tag;
        logic  pin;
        logic  fb;
        logic  en;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    omc_cell #(.NUM_TERMS(NT)) i_omc_cell (
        .clk(clk), .rst_gl(rst_gl), .pre_gl(pre_gl), .terms(terms),
        .cfg_mode(cfg_mode), .cfg_pol(cfg_pol), .cfg_pin_reg(cfg_pin_reg),
        .cfg_fb_reg(cfg_fb_reg), .oe(oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    function automatic logic ref_next(logic [1:0] m, logic q, logic [NT-1:0] t, logic p);
        logic s, a, b;
        s = (|t) ^ p;
        a = t[0] | t[1];
        b = t[2] | t[3];
        case (m)
            2'b00:   return s;
            2'b01:   return s ? ~q : q;
            2'b10:   return (a && b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
            default: return (a && !b) ? 1'b1 : ((b && !a) ? 1'b0 : q);
        endcase
    endfunction

    task automatic step(string tag, logic r, logic pr, logic [1:0] m, logic [NT-1:0] t,
                        logic p, logic preg, logic freg, logic e);
        exp_t it;
        logic comb;
        @(negedge clk);
        rst_gl = r; pre_gl = pr; cfg_mode = m; terms = t; cfg_pol = p;
        cfg_pin_reg = preg; cfg_fb_reg = freg; oe = e;
        comb = (|t) ^ p;
        if (r)       model_q = 1'b0;
        else if (pr) model_q = 1'b1;
        else         model_q = ref_next(m, model_q, t, p);
        it.tag = tag;
        it.pin = preg ? model_q : comb;
        it.fb  = freg ? model_q : comb;
        it.en  = e & ~r;
        sb.push_back(it);
    endtask

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                chk({it.tag, " pin"}, pin_out, it.pin);
                chk({it.tag, " fb"},  fb_out,  it.fb);
                chk({it.tag, " oe"},  pin_oe,  it.en);
            end
        end
    end

    initial begin
        // reset state, R9 with oe requested
        step("R5 R9 reset", 1, 0, 2'b00, 4'b1111, 0, 1, 1, 1);
        step("R5 reset over preset", 1, 1, 2'b00, 4'b1111, 0, 1, 1, 1);
        step("R5 reset held", 1, 0, 2'b00, 4'b0000, 0, 1, 1, 1);
        step("R6 preset", 0, 1, 2'b00, 4'b0000, 0, 1, 1, 1);
        // D mode
        step("R1 D zero", 0, 0, 2'b00, 4'b0000, 0, 1, 1, 1);
        step("R1 D one", 0, 0, 2'b00, 4'b0100, 0, 1, 1, 1);
        step("R1 D pol", 0, 0, 2'b00, 4'b0100, 1, 1, 1, 1);
        step("R1 D pol zero", 0, 0, 2'b00, 4'b0000, 1, 1, 1, 1);
        // T mode
        step("R2 T toggle", 0, 0, 2'b01, 4'b0001, 0, 1, 1, 1);
        step("R2 T toggle2", 0, 0, 2'b01, 4'b1000, 0, 1, 1, 1);
        step("R2 T hold", 0, 0, 2'b01, 4'b0000, 0, 1, 1, 1);
        step("R2 T pol hold", 0, 0, 2'b01, 4'b0010, 1, 1, 1, 1);
        step("R2 T pol toggle", 0, 0, 2'b01, 4'b0000, 1, 1, 1, 1);
        // JK mode
        step("R3 JK clear", 0, 0, 2'b10, 4'b0100, 0, 1, 1, 1);
        step("R3 JK hold", 0, 0, 2'b10, 4'b0000, 0, 1, 1, 1);
        step("R3 JK set", 0, 0, 2'b10, 4'b0010, 0, 1, 1, 1);
        step("R3 JK hold1", 0, 0, 2'b10, 4'b0000, 0, 1, 1, 1);
        step("R3 JK toggle", 0, 0, 2'b10, 4'b1001, 0, 1, 1, 1);
        step("R3 JK toggle2", 0, 0, 2'b10, 4'b0110, 0, 1, 1, 1);
        // SR mode
        step("R4 SR reset", 0, 0, 2'b11, 4'b1000, 0, 1, 1, 1);
        step("R4 SR both hold0", 0, 0, 2'b11, 4'b1111, 0, 1, 1, 1);
        step("R4 SR set", 0, 0, 2'b11, 4'b0001, 0, 1, 1, 1);
        step("R4 SR both hold1", 0, 0, 2'b11, 4'b0101, 0, 1, 1, 1);
        step("R4 SR none hold", 0, 0, 2'b11, 4'b0000, 0, 1, 1, 1);
        // mux selection and buried feedback
        step("R7 R8 pin comb fb reg", 0, 0, 2'b11, 4'b0000, 0, 0, 1, 0);
        step("R7 R8 pin reg fb comb buried", 0, 0, 2'b11, 4'b0000, 1, 1, 0, 0);
        step("R7 R8 both comb", 0, 0, 2'b11, 4'b1010, 0, 0, 0, 1);
        // async reset and preset between edges
        step("R1 D load one", 0, 0, 2'b00, 4'b0001, 0, 1, 1, 1);
        @(negedge clk);
        #3 rst_gl = 1'b1;
        #2 chk("R5 async clear pin", pin_out, 1'b0);
        chk("R9 async oe release", pin_oe, 1'b0);
        rst_gl = 1'b0;
        model_q = 1'b0;
        #2 pre_gl = 1'b1;
        #2 chk("R6 async set pin", pin_out, 1'b1);
        pre_gl = 1'b0;
        model_q = 1'b1;
        step("R2 T after preset", 0, 0, 2'b01, 4'b0001, 0, 1, 1, 1);
        repeat (3) @(posedge clk);
        #6 drv_done = 1'b1;
    end

    initial begin
        fork
            wait (drv_done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule